// File: doc/BRIEF.md
# Ethernet Inter-Packet Gap Timer

This block tells a transmitter when the medium has been quiet long enough for a new frame to begin. It counts bit times and asserts `gap_ok_o` once a full gap of 96 bit times (12 byte times) has passed. The count advances only on a one-clock pulse, `bit_tick_i`, so the same logic serves any MII rate. The clock domain may run faster than the bit rate.

In half-duplex mode the gap is timed from the moment carrier sense falls. The gap has two phases with different rules. During the guard phase (the first 64 bit times), any carrier restarts the count from zero. During the tail phase (the last 32 bit times), carrier is ignored and the count still completes at 96. In full-duplex mode carrier sense plays no part: the gap is timed from the end of the block's own transmission. In both modes, starting a transmission withdraws `gap_ok_o`. In half-duplex mode, a fresh rise of carrier while the gap is already complete also withdraws it.

Top module: `ipg_timer`

## Requirements
- R1: While `rst_ni` is low and right after reset, `gap_ok_o` is 0 and the gap count is zero.
- R2: The count advances by one only in a cycle with `bit_tick_i` high. `gap_ok_o` rises on the clock edge that takes the 96th tick after the last restart, and the count never goes past 96.
- R3: In half-duplex mode (`full_duplex_i` = 0), while `crs_i` is high during the guard phase, the count stays at zero. Counting begins with the first tick after `crs_i` falls.
- R4: In half-duplex mode, `crs_i` high while the count is below 64 clears the count to zero on the next edge. A full 96 ticks are then needed again.
- R5: In half-duplex mode, `crs_i` while the count is from 64 to 95 has no effect: ticks keep counting and `gap_ok_o` still rises at 96, even if `crs_i` stays high.
- R6: In half-duplex mode, a rising edge of `crs_i` (low in the previous cycle, high now) while `gap_ok_o` is 1 drops `gap_ok_o` on the next edge and restarts the count.
- R7: In either mode, `tx_active_i` high clears the count and drops `gap_ok_o` on the next edge. Timing restarts when it falls.
- R8: In full-duplex mode (`full_duplex_i` = 1), `crs_i` is ignored in every phase.
- R9: With no tick and no traffic the count holds. Once reached, `gap_ok_o` stays 1 until traffic clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_tick_i | input | 1 | One-clock pulse per bit time |
| crs_i | input | 1 | Carrier sense |
| tx_active_i | input | 1 | Own transmission in progress |
| full_duplex_i | input | 1 | 1 = full duplex, 0 = half duplex |
| gap_ok_o | output | 1 | Gap complete, a new frame may start |

## Verification
Every result of this block lands exactly one clock edge after the input cycle that causes it. This applies to a tick, a carrier-driven restart or a transmit clear: `gap_ok_o` is a decode of the registered count. The driver therefore holds inputs for one cycle and crosses the next rising edge before it queues the value expected for that cycle. The monitor compares on the following falling edge, away from any input change. The boundary cycles are checked one tick short of and exactly at the 96th tick, and carrier is applied at count 63 and at count 64, either side of the guard-to-tail edge.

// File: rtl/ipg_pkg.sv
package ipg_pkg;
  localparam int unsigned IPG_GAP_BITS   = 96;
  localparam int unsigned IPG_GUARD_BITS = 64;

  typedef enum logic [1:0] {
    PH_GUARD = 2'd0,
    PH_TAIL  = 2'd1,
    PH_DONE  = 2'd2
  } ipg_phase_e;
endpackage

// File: rtl/ipg_edge.sv
module ipg_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/ipg_ctrl.sv
module ipg_ctrl
  import ipg_pkg::*;
#(
  parameter int unsigned CNT_W      = 7,
  parameter int unsigned GAP_BITS   = IPG_GAP_BITS,
  parameter int unsigned GUARD_BITS = IPG_GUARD_BITS
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             crs_i,
  input  logic             crs_rise_i,
  input  logic             tx_active_i,
  input  logic             full_duplex_i,
  output ipg_phase_e       phase_o,
  output logic             clr_o
);
  localparam logic [CNT_W-1:0] GUARD_C = CNT_W'(GUARD_BITS);
  localparam logic [CNT_W-1:0] GAP_C   = CNT_W'(GAP_BITS);

  always_comb begin
    if (cnt_i < GUARD_C)    phase_o = PH_GUARD;
    else if (cnt_i < GAP_C) phase_o = PH_TAIL;
    else                    phase_o = PH_DONE;
  end

  // Guard phase restarts on carrier level; done phase only on a fresh rise.
  always_comb begin
    clr_o = tx_active_i;
    if (!full_duplex_i) begin
      if (crs_i && phase_o == PH_GUARD)      clr_o = 1'b1;
      if (crs_rise_i && phase_o == PH_DONE)  clr_o = 1'b1;
    end
  end
endmodule

// File: rtl/ipg_counter.sv
module ipg_counter #(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned LIMIT = 96
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_o <= '0;
    else if (clr_i)                   cnt_o <= '0;
    else if (tick_i && cnt_o != LIMIT_C) cnt_o <= cnt_o + CNT_W'(1);
  end

  assign done_o = (cnt_o == LIMIT_C);
endmodule

// File: rtl/ipg_timer.sv
module ipg_timer
  import ipg_pkg::*;
#(
  parameter int unsigned GAP_BITS   = IPG_GAP_BITS,
  parameter int unsigned GUARD_BITS = IPG_GUARD_BITS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_tick_i,
  input  logic crs_i,
  input  logic tx_active_i,
  input  logic full_duplex_i,
  output logic gap_ok_o
);
  localparam int unsigned      CNT_W   = $clog2(GAP_BITS + 1);
  localparam logic [CNT_W-1:0] GAP_C   = CNT_W'(GAP_BITS);
  localparam logic [CNT_W-1:0] GUARD_C = CNT_W'(GUARD_BITS);

  logic             crs_rise;
  logic             clr;
  logic [CNT_W-1:0] cnt;
  ipg_phase_e       phase;

  ipg_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (crs_i),
    .rise_o (crs_rise)
  );

  ipg_ctrl #(
    .CNT_W      (CNT_W),
    .GAP_BITS   (GAP_BITS),
    .GUARD_BITS (GUARD_BITS)
  ) u_ctrl (
    .cnt_i         (cnt),
    .crs_i         (crs_i),
    .crs_rise_i    (crs_rise),
    .tx_active_i   (tx_active_i),
    .full_duplex_i (full_duplex_i),
    .phase_o       (phase),
    .clr_o         (clr)
  );

  ipg_counter #(
    .CNT_W (CNT_W),
    .LIMIT (GAP_BITS)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .tick_i (bit_tick_i),
    .cnt_o  (cnt),
    .done_o (gap_ok_o)
  );

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (!gap_ok_o); // R1
    end
  end

  AST_NO_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= GAP_C); // R2

  AST_TX_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_active_i |=> (cnt == '0) && !gap_ok_o); // R7

  AST_GUARD_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_duplex_i && crs_i && cnt < GUARD_C) |=> cnt == '0); // R4

  AST_TAIL_IGNORES_CRS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_duplex_i && !tx_active_i && bit_tick_i && cnt >= GUARD_C && cnt < GAP_C)
    |=> cnt == $past(cnt) + CNT_W'(1)); // R5

  AST_FD_IGNORES_CRS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_duplex_i && !tx_active_i && bit_tick_i && cnt < GAP_C)
    |=> cnt == $past(cnt) + CNT_W'(1)); // R8

  AST_RISE_DROPS_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_duplex_i && gap_ok_o && crs_rise) |=> !gap_ok_o); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_tick_i && !tx_active_i && !crs_i) |=> $stable(cnt)); // R9

  AST_PHASE_DONE_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_ok_o |-> phase == PH_DONE); // R2
endmodule

// File: tb/ipg_timer_bench.sv
`timescale 1ns/100ps
module ipg_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, crs = 1'b0, tx = 1'b0, fd = 1'b0;
  logic gap_ok;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic  val;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  ipg_timer u_ipg_timer (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .bit_tick_i    (tick),
    .crs_i         (crs),
    .tx_active_i   (tx),
    .full_duplex_i (fd),
    .gap_ok_o      (gap_ok)
  );

  task automatic check_now(input string tag, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s gap_ok=%b expected=%b", tag, act, expv);
    end
  endtask

  // One input cycle; expectation queued after the edge it takes effect on.
  task automatic step(input logic tk, input logic c, input logic t, input logic f,
                      input bit chk, input logic ev, input string tag);
    @(negedge clk);
    tick = tk; crs = c; tx = t; fd = f;
    @(posedge clk);
    #1;
    if (chk) exp_q.push_back('{val: ev, tag: tag});
  endtask

  task automatic ticks(input int n, input logic c, input logic f,
                       input bit chk, input logic ev, input string tag);
    for (int i = 0; i < n; i++)
      step(1'b1, c, 1'b0, f, chk && (i == n - 1), ev, tag);
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check_now(e.tag, gap_ok, e.val);
      end
    end
  end

  // Watchdog
  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired gap_ok=%b expected=done", gap_ok);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check_now("R1 in reset", gap_ok, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    step(1'b0, 0, 0, 0, 1, 1'b0, "R1 after reset");
    step(1'b0, 0, 0, 0, 1, 1'b0, "R1 idle no tick");

    // R2: 96 ticks from reset
    ticks(95, 0, 0, 1, 1'b0, "R2 tick 95");
    ticks(1, 0, 0, 1, 1'b1, "R2 tick 96");
    step(1'b0, 0, 0, 0, 1, 1'b1, "R9 hold no tick");
    ticks(5, 0, 0, 1, 1'b1, "R9 saturate");

    // R6: carrier rises while gap complete
    step(1'b0, 1, 0, 0, 1, 1'b0, "R6 rise drops ok");
    // R3: carrier held keeps count at zero
    ticks(10, 1, 0, 1, 1'b0, "R3 crs held");
    ticks(95, 0, 0, 1, 1'b0, "R3 tick 95 after fall");
    ticks(1, 0, 0, 1, 1'b1, "R3 tick 96 after fall");

    // R4: carrier at count 63 restarts
    step(1'b0, 0, 1, 0, 1, 1'b0, "R7 tx clears half");
    ticks(63, 0, 0, 1, 1'b0, "R4 reach 63");
    step(1'b0, 1, 0, 0, 1, 1'b0, "R4 crs at 63");
    ticks(95, 0, 0, 1, 1'b0, "R4 tick 95 after restart");
    ticks(1, 0, 0, 1, 1'b1, "R4 tick 96 after restart");

    // R5: carrier from count 64 onward ignored
    step(1'b0, 0, 1, 0, 1, 1'b0, "R7 tx clears again");
    ticks(64, 0, 0, 1, 1'b0, "R5 reach 64");
    ticks(31, 1, 0, 1, 1'b0, "R5 tick 95 with crs");
    ticks(1, 1, 0, 1, 1'b1, "R5 tick 96 with crs");
    step(1'b0, 1, 0, 0, 1, 1'b1, "R5 crs level held");
    step(1'b0, 0, 0, 0, 1, 1'b1, "R5 crs fall");

    // R7: tx held
    step(1'b0, 0, 1, 0, 1, 1'b0, "R7 tx start");
    for (int i = 0; i < 5; i++) step(1'b1, 0, 1, 0, (i == 4), 1'b0, "R7 tx held with ticks");
    ticks(95, 0, 0, 1, 1'b0, "R7 tick 95 after tx");
    ticks(1, 0, 0, 1, 1'b1, "R7 tick 96 after tx");

    // R8: full duplex ignores carrier
    step(1'b0, 1, 0, 1, 1, 1'b1, "R8 crs rise ignored");
    step(1'b0, 1, 1, 1, 1, 1'b0, "R7 tx clears full");
    ticks(10, 1, 1, 1, 1'b0, "R8 crs in guard ignored");
    ticks(85, 1, 1, 1, 1'b0, "R8 tick 95");
    ticks(1, 1, 1, 1, 1'b1, "R8 tick 96");
    step(1'b0, 0, 0, 1, 1, 1'b1, "R8 crs fall ignored");

    repeat (3) @(negedge clk);
    done = 1'b1;
    if (exp_q.size() != 0) begin
      failures++;
      checks++;
      $display("FAIL scoreboard left=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule